// File: doc/BRIEF.md
# Fault Capture and Severity Routing Register

This block gathers single-cycle error pulses from up to 64 sources into a sticky fault register. A fault bit stays set until software clears it. Every fault bit that is not masked is sent to exactly one of four reaction outputs: system checkstop, recoverable error, host attention or unit checkstop. The choice comes from two per-bit action registers. The reaction outputs are levels, and each one stays high while at least one unmasked fault bit routed to it is set.

Software reaches the block through a plain synchronous register port made of an address, a write enable, write data and registered read data. The port gives access to the fault register, the mask and the two action registers. The fault register also has a set-only write alias and a clear-only write alias, so that individual bits can be changed without a read-modify-write. After reset every source is masked. Firmware programs the actions first and then opens the mask.

Top module: `fault_route_reg`

## Requirements
- R1: Reset behaviour (synchronous active-low reset):
  - Reset leaves the mask at all ones, both action registers at zero and the fault register at zero.
  - All four reaction outputs are low after reset.
- R2: A source pulse on `src_err[i]` sets fault bit i on the next clock edge. The bit then stays set until software clears it.
- R3: A fault bit whose mask bit is 1 drives no reaction output, whatever its action bits hold.
- R4: An unmasked set fault bit with action0=0 and action1=0 drives `chk_sys_o`.
- R5: An unmasked set fault bit with action0=0 and action1=1 drives `recov_o`.
- R6: An unmasked set fault bit with action0=1 and action1=0 drives `host_attn_o`.
- R7: An unmasked set fault bit with action0=1 and action1=1 drives `chk_unit_o`.
- R8: A write to address 0 replaces the whole fault register with the write data, ORed with any source pulses in the same cycle.
- R9: A write to address 1 ORs the write data into the fault register.
- R10: A write to address 2 clears every fault bit whose write-data bit is 1. A source pulse on a bit in the same cycle keeps that bit set.
- R11: Each reaction output changes exactly one clock edge after the change to the fault, mask or action register that causes it.
- R12: Read data shows, one cycle after the address is presented, the register at that address:
  - Addresses 0, 1 and 2 return the fault register.
  - Address 3 returns the mask, address 4 action0 and address 5 action1.
  - Addresses 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_err | input | N_SRC | Error pulses, one per source |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write enable for the addressed register |
| reg_wdata | input | N_SRC | Write data |
| reg_rdata | output | N_SRC | Registered read data |
| chk_sys_o | output | 1 | System checkstop reaction |
| recov_o | output | 1 | Recoverable error reaction |
| host_attn_o | output | 1 | Host attention reaction |
| chk_unit_o | output | 1 | Unit checkstop reaction |

## Verification
The bench sends a source pulse in the same cycle as a clear-alias write to the same bit. A design that gave priority to the clear would lose the error, and the recoverable output would drop.

It places one fault bit under each of the four action codes. A design with swapped action bits would raise host attention where recoverable is expected. It also checks the output in the cycle right after a register write, so an output that is combinational or delayed by two cycles shows a mismatch.

With every bit masked, fault bits are still captured but must drive no output. This catches a design that ignores the mask or resets the mask to zero. A long randomised run of writes to all eight addresses is compared every cycle against a behavioural model. That run exercises the aliases, the direct write and the zero reads of unused addresses.

// File: rtl/fault_route_pkg.sv
// Package: shared constants for the fault capture and routing register.
// Assumes a three-bit register address; the address map is fixed here.
package fault_route_pkg;

    localparam int unsigned ADDR_W = 3;

    // Register address map
    localparam logic [ADDR_W-1:0] A_FAULT = 3'd0;
    localparam logic [ADDR_W-1:0] A_FSET  = 3'd1;
    localparam logic [ADDR_W-1:0] A_FCLR  = 3'd2;
    localparam logic [ADDR_W-1:0] A_MASK  = 3'd3;
    localparam logic [ADDR_W-1:0] A_ACT0  = 3'd4;
    localparam logic [ADDR_W-1:0] A_ACT1  = 3'd5;

    // Reaction class index equals the action code {action0, action1}
    localparam int unsigned N_CLASS = 4;
    localparam int unsigned CL_SYS  = 0;
    localparam int unsigned CL_REC  = 1;
    localparam int unsigned CL_HOST = 2;
    localparam int unsigned CL_UNIT = 3;

endpackage

// File: rtl/fault_store.sv
// Module: fault_store
// Holds the sticky fault bits. Source pulses set bits; software writes
// replace, OR into or clear the register through three addresses.
// Assumes single-cycle write strobes; a source pulse beats a clear.
module fault_store
    import fault_route_pkg::*;
#(
    parameter int unsigned N_SRC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_err,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N_SRC-1:0]  wr_data,
    output logic [N_SRC-1:0]  fault_q
);

    logic [N_SRC-1:0] base_d;

    // Select the software-modified value before source pulses merge in
    always_comb begin
        base_d = fault_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_FAULT: base_d = wr_data;
                A_FSET:  base_d = fault_q | wr_data;
                A_FCLR:  base_d = fault_q & ~wr_data;
                default: base_d = fault_q;
            endcase
        end
    end

    // Register the fault bits with source pulses taking priority
    always_ff @(posedge clk) begin
        if (!rst_n) fault_q <= '0;
        else        fault_q <= base_d | src_err;
    end

endmodule

// File: rtl/fault_cfg.sv
// Module: fault_cfg
// Holds the mask and the two action registers. The mask resets to all ones
// so every source starts masked; the action registers reset to zero.
// Assumes full-width writes only.
module fault_cfg
    import fault_route_pkg::*;
#(
    parameter int unsigned N_SRC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [N_SRC-1:0]  wr_data,
    output logic [N_SRC-1:0]  mask_q,
    output logic [N_SRC-1:0]  act0_q,
    output logic [N_SRC-1:0]  act1_q
);

    // Update the mask register on a write to its address
    always_ff @(posedge clk) begin
        if (!rst_n)                          mask_q <= '1;
        else if (wr_en && wr_addr == A_MASK) mask_q <= wr_data;
    end

    // Update the action0 register on a write to its address
    always_ff @(posedge clk) begin
        if (!rst_n)                          act0_q <= '0;
        else if (wr_en && wr_addr == A_ACT0) act0_q <= wr_data;
    end

    // Update the action1 register on a write to its address
    always_ff @(posedge clk) begin
        if (!rst_n)                          act1_q <= '0;
        else if (wr_en && wr_addr == A_ACT1) act1_q <= wr_data;
    end

endmodule

// File: rtl/fault_route.sv
// Module: fault_route
// Decodes the two action bits of every source into one of four classes,
// then ORs the unmasked fault bits of each class into a registered output.
// Assumes class index equals the code {action0, action1}.
module fault_route
    import fault_route_pkg::*;
#(
    parameter int unsigned N_SRC = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   fault,
    input  logic [N_SRC-1:0]   mask,
    input  logic [N_SRC-1:0]   act0,
    input  logic [N_SRC-1:0]   act1,
    output logic [N_CLASS-1:0] react_q
);

    logic [N_SRC-1:0]   live;
    logic [N_CLASS-1:0] hit;

    // Faults that are allowed to reach any reaction
    assign live = fault & ~mask;

    for (genvar c = 0; c < N_CLASS; c++) begin : g_class
        localparam logic [1:0] CODE = 2'(c);
        logic [N_SRC-1:0] sel;
        // Bits whose action code matches this class
        assign sel    = (CODE[1] ? act0 : ~act0) & (CODE[0] ? act1 : ~act1);
        assign hit[c] = |(live & sel);
    end

    // Register the per-class reductions
    always_ff @(posedge clk) begin
        if (!rst_n) react_q <= '0;
        else        react_q <= hit;
    end

endmodule

// File: rtl/fault_rdport.sv
// Module: fault_rdport
// Registered read multiplexer. The fault register answers at its own address
// and both alias addresses; unused addresses read zero.
// Assumes the address is held for the cycle of interest.
module fault_rdport
    import fault_route_pkg::*;
#(
    parameter int unsigned N_SRC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [N_SRC-1:0]  fault,
    input  logic [N_SRC-1:0]  mask,
    input  logic [N_SRC-1:0]  act0,
    input  logic [N_SRC-1:0]  act1,
    output logic [N_SRC-1:0]  rd_data_q
);

    logic [N_SRC-1:0] rd_d;

    // Pick the addressed register
    always_comb begin
        unique case (rd_addr)
            A_FAULT, A_FSET, A_FCLR: rd_d = fault;
            A_MASK:                  rd_d = mask;
            A_ACT0:                  rd_d = act0;
            A_ACT1:                  rd_d = act1;
            default:                 rd_d = '0;
        endcase
    end

    // Register the read data
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data_q <= '0;
        else        rd_data_q <= rd_d;
    end

endmodule

// File: rtl/fault_route_reg.sv
// Module: fault_route_reg (top)
// Sticky fault register with mask and two-bit per-source action codes
// routing each unmasked fault to one of four severity outputs.
// Assumes a synchronous active-low reset and one register access per cycle.
module fault_route_reg
    import fault_route_pkg::*;
#(
    parameter int unsigned N_SRC = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_err,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [N_SRC-1:0]  reg_wdata,
    output logic [N_SRC-1:0]  reg_rdata,
    output logic              chk_sys_o,
    output logic              recov_o,
    output logic              host_attn_o,
    output logic              chk_unit_o
);

    logic [N_SRC-1:0]   fault_q;
    logic [N_SRC-1:0]   mask_q;
    logic [N_SRC-1:0]   act0_q;
    logic [N_SRC-1:0]   act1_q;
    logic [N_CLASS-1:0] react_q;

    fault_store #(.N_SRC(N_SRC)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .src_err (src_err),
        .wr_en   (reg_we),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .fault_q (fault_q)
    );

    fault_cfg #(.N_SRC(N_SRC)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_we),
        .wr_addr (reg_addr),
        .wr_data (reg_wdata),
        .mask_q  (mask_q),
        .act0_q  (act0_q),
        .act1_q  (act1_q)
    );

    fault_route #(.N_SRC(N_SRC)) u_route (
        .clk     (clk),
        .rst_n   (rst_n),
        .fault   (fault_q),
        .mask    (mask_q),
        .act0    (act0_q),
        .act1    (act1_q),
        .react_q (react_q)
    );

    fault_rdport #(.N_SRC(N_SRC)) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_addr   (reg_addr),
        .fault     (fault_q),
        .mask      (mask_q),
        .act0      (act0_q),
        .act1      (act1_q),
        .rd_data_q (reg_rdata)
    );

    assign chk_sys_o   = react_q[CL_SYS];
    assign recov_o     = react_q[CL_REC];
    assign host_attn_o = react_q[CL_HOST];
    assign chk_unit_o  = react_q[CL_UNIT];

endmodule

// File: rtl/fault_route_chk.sv
// Module: fault_route_chk
// Property checker bound to fault_route_reg; observes ports and the
// register state held in the storage, configuration and routing submodules.
module fault_route_chk
    import fault_route_pkg::*;
#(
    parameter int unsigned N_SRC = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  src_err,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_we,
    input logic [N_SRC-1:0]  reg_rdata,
    input logic              chk_sys_o,
    input logic              recov_o,
    input logic              host_attn_o,
    input logic              chk_unit_o,
    input logic [N_SRC-1:0]  fault_q,
    input logic [N_SRC-1:0]  mask_q,
    input logic [N_SRC-1:0]  act0_q,
    input logic [N_SRC-1:0]  act1_q
);

    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> ((&mask_q) && act0_q == '0 && act1_q == '0
                           && !chk_sys_o && !recov_o && !host_attn_o && !chk_unit_o));

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((fault_q & $past(src_err)) == $past(src_err)));

    // R2
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !($past(reg_we) && ($past(reg_addr) == A_FAULT || $past(reg_addr) == A_FCLR)))
        |-> ((fault_q & $past(fault_q)) == $past(fault_q)));

    // R3
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((fault_q & ~mask_q) == '0) |=> (!chk_sys_o && !recov_o && !host_attn_o && !chk_unit_o));

    // R7
    unit_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(fault_q & ~mask_q & act0_q & act1_q)) |=> chk_unit_o);

    // R12
    unused_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_addr) >= 3'd6) |-> (reg_rdata == '0));

    // R12
    mask_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_addr) == A_MASK) |-> (reg_rdata == $past(mask_q)));

endmodule

bind fault_route_reg fault_route_chk #(.N_SRC(N_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_err     (src_err),
    .reg_addr    (reg_addr),
    .reg_we      (reg_we),
    .reg_rdata   (reg_rdata),
    .chk_sys_o   (chk_sys_o),
    .recov_o     (recov_o),
    .host_attn_o (host_attn_o),
    .chk_unit_o  (chk_unit_o),
    .fault_q     (fault_q),
    .mask_q      (mask_q),
    .act0_q      (act0_q),
    .act1_q      (act1_q)
);

// File: tb/sim_fault_route_reg.sv
`timescale 1ns/1ps
module sim_fault_route_reg;

    localparam int N = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] src_err = '0;
    logic [2:0]   reg_addr = '0;
    logic         reg_we = 1'b0;
    logic [N-1:0] reg_wdata = '0;
    logic [N-1:0] reg_rdata;
    logic         chk_sys_o, recov_o, host_attn_o, chk_unit_o;

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    fault_route_reg #(.N_SRC(N)) u0 (
        .clk(clk), .rst_n(rst_n), .src_err(src_err), .reg_addr(reg_addr),
        .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .chk_sys_o(chk_sys_o), .recov_o(recov_o),
        .host_attn_o(host_attn_o), .chk_unit_o(chk_unit_o)
    );

    // Behavioural reference model
    logic [N-1:0] m_fault, m_mask, m_a0, m_a1, m_rd;
    logic [3:0]   m_out;

    function automatic logic [3:0] classify(logic [N-1:0] f, logic [N-1:0] m,
                                            logic [N-1:0] a0, logic [N-1:0] a1);
        logic [3:0] r = '0;
        for (int i = 0; i < N; i++) begin
            if (f[i] && !m[i]) r[{a0[i], a1[i]}] = 1'b1;
        end
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_fault = '0; m_mask = '1; m_a0 = '0; m_a1 = '0;
            m_rd = '0; m_out = '0;
        end else begin
            m_out = classify(m_fault, m_mask, m_a0, m_a1);
            case (reg_addr)
                3'd0, 3'd1, 3'd2: m_rd = m_fault;
                3'd3: m_rd = m_mask;
                3'd4: m_rd = m_a0;
                3'd5: m_rd = m_a1;
                default: m_rd = '0;
            endcase
            if (reg_we) begin
                case (reg_addr)
                    3'd0: m_fault = reg_wdata;
                    3'd1: m_fault = m_fault | reg_wdata;
                    3'd2: m_fault = m_fault & ~reg_wdata;
                    3'd3: m_mask = reg_wdata;
                    3'd4: m_a0 = reg_wdata;
                    3'd5: m_a1 = reg_wdata;
                    default: ;
                endcase
            end
            m_fault = m_fault | src_err;
        end
        started = 1;
    end

    task automatic chk(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (started && !done) begin
            chk("R12 rdata", reg_rdata, m_rd);
            chk("R4 sys", N'(chk_sys_o), N'(m_out[0]));
            chk("R5 recov", N'(recov_o), N'(m_out[1]));
            chk("R6 host", N'(host_attn_o), N'(m_out[2]));
            chk("R7 unit", N'(chk_unit_o), N'(m_out[3]));
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [N-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_we = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse(logic [N-1:0] b);
        @(negedge clk);
        src_err = b;
        @(negedge clk);
        src_err = '0;
    endtask

    task automatic rd(logic [2:0] a, output logic [N-1:0] d);
        @(negedge clk);
        reg_addr = a;
        @(negedge clk);
        d = reg_rdata;
    endtask

    task automatic finish_run();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [N-1:0] v;
        tick(3);
        rst_n = 1'b1;
        // R1: reset values
        rd(3'd3, v); chk("R1 mask reset", v, '1);
        rd(3'd4, v); chk("R1 act0 reset", v, '0);
        rd(3'd0, v); chk("R1 fault reset", v, '0);
        rd(3'd6, v); chk("R12 unused 6", v, '0);
        // R2/R3: captured while masked, no outputs
        pulse(64'hF);
        tick(1);
        chk("R3 masked quiet", N'({chk_sys_o, recov_o, host_attn_o, chk_unit_o}), '0);
        rd(3'd0, v); chk("R2 captured", v, 64'hF);
        tick(3);
        rd(3'd1, v); chk("R2 sticky", v, 64'hF);
        // R4-R7: code {action0,action1} per bit 0..3 = 00,01,10,11
        wr(3'd4, 64'hC);
        wr(3'd5, 64'hA);
        wr(3'd3, ~64'hF);
        tick(1);
        chk("R4 sys", N'(chk_sys_o), 1);
        chk("R5 recov", N'(recov_o), 1);
        chk("R6 host", N'(host_attn_o), 1);
        chk("R7 unit", N'(chk_unit_o), 1);
        // R10/R11: clear bit0; output still high right after, low a cycle later
        wr(3'd2, 64'h1);
        chk("R11 one cycle late", N'(chk_sys_o), 1);
        tick(1);
        chk("R10 clear sys", N'(chk_sys_o), 0);
        // R10: clear races a pulse on bit1; pulse wins
        @(negedge clk);
        reg_addr = 3'd2; reg_we = 1'b1; reg_wdata = 64'h2; src_err = 64'h2;
        @(negedge clk);
        reg_we = 1'b0; src_err = '0;
        tick(1);
        chk("R10 pulse wins", N'(recov_o), 1);
        rd(3'd0, v); chk("R10 fault after race", v, 64'hE);
        // R9: set alias on bit 63, unmasked with code 00
        wr(3'd1, 64'h8000_0000_0000_0000);
        wr(3'd3, ~64'h8000_0000_0000_000F);
        tick(1);
        chk("R9 set alias sys", N'(chk_sys_o), 1);
        rd(3'd2, v); chk("R9 fault", v, 64'h8000_0000_0000_000E);
        // R8: direct writes
        wr(3'd0, 64'h0);
        tick(1);
        chk("R8 cleared outputs", N'({chk_sys_o, recov_o, host_attn_o, chk_unit_o}), '0);
        wr(3'd0, 64'h5);
        rd(3'd0, v); chk("R8 replace", v, 64'h5);
        // R3: mask everything again
        wr(3'd3, '1);
        tick(1);
        chk("R3 remask quiet", N'({chk_sys_o, recov_o, host_attn_o, chk_unit_o}), '0);
        rd(3'd7, v); chk("R12 unused 7", v, '0);
        // Random traffic against the model
        for (int k = 0; k < 600; k++) begin
            @(negedge clk);
            reg_addr  = 3'($urandom_range(0, 7));
            reg_we    = ($urandom_range(0, 2) == 0);
            reg_wdata = {$urandom, $urandom} & {$urandom, $urandom};
            src_err   = ($urandom_range(0, 3) == 0) ?
                        ({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom}) : '0;
        end
        @(negedge clk);
        reg_we = 1'b0; src_err = '0;
        tick(2);
        finish_run();
    end

endmodule